// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block answers on a two-wire serial bus as a small byte-addressed memory of 1024 bytes. A controller on the bus selects it with a 7-bit device address whose top nibble is the constant 1010. It can then store one byte, or several bytes at incrementing addresses, at a 10-bit word address. It can also set the word address and, after a repeated START, read bytes back. The two upper bits of the word address travel in the device address byte. The remaining 8 bits follow in a separate word-address byte.

Both bus lines enter as plain inputs. They are sampled with the system clock through synchronizers, and the block only ever pulls SDA low, through a registered pull-down enable. The block never stretches SCL, so the bus clock must be many times slower than the system clock. After a write transfer closes with STOP, the block runs an internal write-cycle timer. While that timer runs, it refuses its own address with a NACK. The storage holds its contents only while powered.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, and whenever the block is not acknowledging or sending a 0 bit, `sda_pull` is low, which leaves SDA released.
- R2: The control byte is sent MSB first and is acknowledged (SDA held low in the ninth clock) only when its bits [7:4] equal 1010 and its bit [3] equals `strap_i`. Any other control byte gets no ACK, and the block ignores the bus until the next START.
- R3: Bits [2:1] of the control byte become word-address bits [9:8], and bit [0] is the direction (0 = write, 1 = read). The following word-address byte supplies bits [7:0].
- R4: In a write transfer, the block acknowledges the word-address byte and each data byte. Each data byte is stored at the current word address, and the word address then increments.
- R5: A control byte with direction 1 makes the block drive the byte at the current word address, MSB first, changing SDA only while SCL is low.
- R6: After each byte the block sends, the word address increments and wraps from 1023 to 0. A controller ACK makes the block send the next byte.
- R7: A controller NACK after a sent byte makes the block release SDA and keep it released until the next START or STOP.
- R8: A STOP that ends a transfer in which at least one data byte was stored starts a timer of `WR_BUSY_CYCLES` system clocks. While the timer runs, matching control bytes are not acknowledged. After it expires they are acknowledged again.
- R9: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START at any point, including in the middle of a byte, restarts reception of a control byte. The block changes its SDA output only after a falling edge of the synchronized SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| strap_i | input | STRAP_W (1) | Board strap compared with control-byte bit 3 |
| sda_pull | output | 1 | When high, the block pulls SDA low |

## Verification
The bench keeps the default 10-bit word address, so the wrap from word 1023 to word 0 is reached within a two-byte sequential read. It builds the block with `WR_BUSY_CYCLES` = 600. This makes the refusal window short enough to probe it with a full control byte inside the window and to see acknowledgement return right after it. The bench's bus clock uses a quarter period of 10 system clocks, which leaves room for the synchronizer latency before each acknowledge and each data bit must be on the line.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam logic [3:0] DEV_FAMILY = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_WAIT
  } ee_state_t;

  typedef enum logic [1:0] {
    K_CTRL,
    K_WADDR,
    K_DATA
  } ee_kind_t;
endpackage

// File: rtl/ee_bus_sense.sv
module ee_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[SYNC_STAGES-1];
      sda_d    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[SYNC_STAGES-1];
  assign sda_s    = sda_pipe[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  // R9
  cond_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_c, stop_c, scl_rise, scl_fall}));
endmodule

// File: rtl/ee_byte_store.sv
module ee_byte_store #(
  parameter int AW = 10,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/ee_busy_timer.sv
module ee_busy_timer #(
  parameter int CYCLES = 250000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic busy
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)              remain <= '0;
    else if (kick)        remain <= CW'(CYCLES);
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign busy = (remain != 0);

  // R8
  busy_countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !kick) |=> (remain == $past(remain) - 1'b1));

  // R8
  busy_load_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> busy);
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_ee_pkg::*;
#(
  parameter int AW             = 10,
  parameter int WR_BUSY_CYCLES = 250000,
  parameter int SYNC_STAGES    = 2,
  localparam int BLK_W   = AW - 8,
  localparam int STRAP_W = 3 - BLK_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_pull
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic busy, kick;

  ee_state_t     state;
  ee_kind_t      kind;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, txsh;
  logic [AW-1:0] addr;
  logic          rd_dir, wr_pend, m_ack;
  logic [7:0]    rdata;
  logic          mem_we, byte_end, dev_hit;

  ee_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  ee_byte_store #(.AW(AW), .DW(8)) u_store (
    .clk(clk), .we(mem_we), .waddr(addr), .wdata(shreg),
    .raddr(addr), .rdata(rdata)
  );

  ee_busy_timer #(.CYCLES(WR_BUSY_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .kick(kick), .busy(busy)
  );

  assign byte_end = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
  assign mem_we   = byte_end && (kind == K_DATA);
  assign kick     = stop_c && wr_pend;
  assign dev_hit  = (shreg[7:4] == DEV_FAMILY) &&
                    (shreg[3 -: STRAP_W] == strap_i) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      kind     <= K_CTRL;
      bitcnt   <= '0;
      shreg    <= '0;
      txsh     <= '0;
      addr     <= '0;
      rd_dir   <= 1'b0;
      wr_pend  <= 1'b0;
      m_ack    <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_c) begin
      state    <= ST_RX;
      kind     <= K_CTRL;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else if (stop_c) begin
      state    <= ST_IDLE;
      wr_pend  <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end
          if (byte_end) begin
            bitcnt <= '0;
            case (kind)
              K_CTRL: begin
                if (dev_hit) begin
                  state                <= ST_ACK;
                  sda_pull             <= 1'b1;
                  addr[AW-1 -: BLK_W]  <= shreg[BLK_W:1];
                  rd_dir               <= shreg[0];
                end else begin
                  state <= ST_WAIT;
                end
              end
              K_WADDR: begin
                state      <= ST_ACK;
                sda_pull   <= 1'b1;
                addr[7:0]  <= shreg;
              end
              default: begin
                state    <= ST_ACK;
                sda_pull <= 1'b1;
                addr     <= addr + 1'b1;
                wr_pend  <= 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (kind == K_CTRL && rd_dir) begin
              txsh     <= rdata;
              sda_pull <= ~rdata[7];
              bitcnt   <= '0;
              state    <= ST_TX;
            end else begin
              sda_pull <= 1'b0;
              state    <= ST_RX;
              kind     <= (kind == K_CTRL) ? K_WADDR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) bitcnt <= bitcnt + 1'b1;
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_pull <= 1'b0;
              bitcnt   <= '0;
              addr     <= addr + 1'b1;
              state    <= ST_RACK;
            end else begin
              sda_pull <= ~txsh[6];
              txsh     <= {txsh[6:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) m_ack <= ~sda_s;
          if (scl_fall) begin
            if (m_ack) begin
              txsh     <= rdata;
              sda_pull <= ~rdata[7];
              state    <= ST_TX;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R9
  sda_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_pull != $past(sda_pull)) |-> ($past(scl_fall) || $past(start_c) || $past(stop_c)));

  // R7
  wait_released_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !sda_pull);

  // R8
  no_ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_pull) && state == ST_ACK && kind == K_CTRL) |-> !busy);

  // R4
  store_only_data_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (state == ST_ACK) && sda_pull);
endmodule

// File: tb/i2c_eeprom_target_bench.sv
module i2c_eeprom_target_bench;
  localparam int QTR  = 10;
  localparam int BUSY = 600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [0:0] strap_r = 1'b0;
  logic sda_pull;
  logic sda_bus;
  int checks = 0;
  int fails = 0;
  int edge_viol = 0;
  logic prev_pull = 1'b0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  i2c_eeprom_target #(.WR_BUSY_CYCLES(BUSY)) u_i2c_eeprom_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(strap_r), .sda_pull(sda_pull)
  );

  // R9 monitor: the pull-down may only change while SCL is low
  always @(negedge clk) begin
    if (!rst) begin
      if (sda_pull !== prev_pull && scl_m) edge_viol++;
      prev_pull = sda_pull;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; q(); scl_m = 1'b1; q();
    ack = !sda_bus;
    q(); scl_m = 1'b0; q();
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; q(); scl_m = 1'b1; q();
      d[i] = sda_bus;
      q(); scl_m = 1'b0; q();
    end
    put_bit(!give_ack);
    sda_m = 1'b1;
  endtask

  task automatic ee_write(input logic [7:0] ctl, input logic [7:0] wa, input logic [7:0] d);
    logic a;
    bus_start();
    send_byte(ctl, a);  chk(a, "R2 control ack", a, 1);
    send_byte(wa, a);   chk(a, "R4 word address ack", a, 1);
    send_byte(d, a);    chk(a, "R4 data ack", a, 1);
    bus_stop();
  endtask

  task automatic ee_read(input logic [7:0] ctl, input logic [7:0] wa, output logic [7:0] d);
    logic a;
    bus_start();
    send_byte(ctl, a);
    send_byte(wa, a);
    bus_start();
    send_byte(ctl | 8'h01, a);
    chk(a, "R5 read control ack", a, 1);
    get_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic probe(input logic [7:0] ctl, output logic a);
    bus_start();
    send_byte(ctl, a);
    bus_stop();
  endtask

  task automatic t_reset();
    chk(sda_pull == 1'b0, "R1 reset release", sda_pull, 0);
    chk(sda_bus == 1'b1, "R1 bus idle high", sda_bus, 1);
  endtask

  task automatic t_write_busy();
    logic a;
    ee_write(8'hA0, 8'h03, 8'h34);
    probe(8'hA0, a);
    chk(!a, "R8 nack while busy", a, 0);
    repeat (BUSY + 100) @(negedge clk);
    probe(8'hA0, a);
    chk(a, "R8 ack after busy", a, 1);
  endtask

  task automatic t_random_read();
    logic [7:0] d;
    ee_read(8'hA0, 8'h03, d);
    chk(d == 8'h34, "R5 random read", d, 8'h34);
  endtask

  task automatic t_block_bits();
    logic [7:0] d;
    ee_write(8'hA4, 8'h03, 8'hA5);
    repeat (BUSY + 100) @(negedge clk);
    ee_read(8'hA0, 8'h03, d);
    chk(d == 8'h34, "R3 block 0 kept", d, 8'h34);
    ee_read(8'hA4, 8'h03, d);
    chk(d == 8'hA5, "R3 block 2 read", d, 8'hA5);
  endtask

  task automatic t_addr_match();
    logic a;
    probe(8'hB0, a);
    chk(!a, "R2 wrong family nack", a, 0);
    probe(8'hA8, a);
    chk(!a, "R2 strap mismatch nack", a, 0);
    strap_r = 1'b1;
    q();
    probe(8'hA8, a);
    chk(a, "R2 strap 1 ack", a, 1);
    probe(8'hA0, a);
    chk(!a, "R2 strap 1 rejects bit3=0", a, 0);
    strap_r = 1'b0;
    q();
  endtask

  task automatic t_wrap_nack();
    logic [7:0] d0, d1;
    logic a;
    int lows;
    ee_write(8'hA6, 8'hFF, 8'h5C);
    repeat (BUSY + 100) @(negedge clk);
    ee_write(8'hA0, 8'h00, 8'h11);
    repeat (BUSY + 100) @(negedge clk);
    bus_start();
    send_byte(8'hA6, a);
    send_byte(8'hFF, a);
    bus_start();
    send_byte(8'hA7, a);
    get_byte(1'b1, d0);
    chk(d0 == 8'h5C, "R6 byte at 1023", d0, 8'h5C);
    get_byte(1'b0, d1);
    chk(d1 == 8'h11, "R6 wrap to 0", d1, 8'h11);
    lows = 0;
    for (int i = 0; i < 9; i++) begin
      sda_m = 1'b1; q(); scl_m = 1'b1; q();
      if (!sda_bus) lows++;
      q(); scl_m = 1'b0; q();
    end
    chk(lows == 0, "R7 released after nack", lows, 0);
    bus_stop();
  endtask

  task automatic t_restart_mid_byte();
    logic a;
    bus_start();
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_start();
    send_byte(8'hA0, a);
    chk(a, "R9 start mid byte restarts", a, 1);
    bus_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_busy();
    t_random_read();
    t_block_bits();
    t_addr_match();
    t_wrap_nack();
    t_restart_mid_byte();
    chk(edge_viol == 0, "R9 sda changes only with scl low", edge_viol, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule